// File: doc/BRIEF.md
# HDLC Frame Transmitter

This block turns a stream of bytes into bit-oriented HDLC frames on a single NRZ serial line. Bytes come in through a valid/ready handshake and are held in a one-byte register. The last byte of a frame is tagged with an end marker. A bit-clock enable sets the line rate, and every change of line state happens only on cycles where that enable is high.

Each frame is sent as follows. The request-to-send line goes up first, and a short run of ones goes out before the opening flag. The payload follows, then a 16-bit CRC-CCITT check sequence, then the closing flag. Inside the payload and the check sequence a zero is inserted after every run of five ones, so the flag pattern cannot appear there. Between frames the line idles at continuous ones and request-to-send is low. A frame does not begin while clear-to-send is inactive, unless a configuration input forces it true. If the byte source runs dry before the end marker, the frame is aborted with a run of ones and an underrun flag is raised.

Top module: `hdlc_frame_tx`

## Requirements
- R1: After reset, `txd` is 1, `rts` is 0, `underrun` is 0 and `in_ready` is 1. Whenever `rts` is 0, `txd` is 1 (all-ones idle fill).
- R2: A frame starts only on a `bit_en` cycle where a byte is held and `cts` or `cts_force` is 1. Otherwise `rts` stays 0 indefinitely.
- R3: `rts` rises together with LEAD_BITS one-bits, which are followed by the opening flag 0x7E. Each line bit lasts one `bit_en` period, and the flag is sent bit 0 first.
- R4: Payload bytes are sent least significant bit first, in the order they were accepted.
- R5: The check sequence follows the payload. It is computed as a reflected CRC-CCITT: right-shifting register, polynomial 0x8408, preset to 0xFFFF at each frame, covering payload bits only. It is sent ones-complemented, low byte first, LSB first. Over the ASCII bytes "123456789" the sent value is 0x906E.
- R6: In the payload and check sequence, a 0 is inserted after every five consecutive 1 bits. This includes a pending insertion before the closing flag. No insertion happens inside flags or the abort run.
- R7: The closing flag 0x7E follows the check sequence. `rts` falls at the `bit_en` after its last bit, and stays 0 for at least one bit time before the next frame.
- R8: If the holding register is empty when a non-final byte finishes, the block sends ABORT_BITS (≥7) ones and no check sequence or flag. It then sets `underrun`, which stays 1 until the next frame starts.
- R9: On cycles with `bit_en` low, `txd` and `rts` do not change.
- R10: `in_ready` is 1 exactly when the holding register is empty. A byte is accepted on a cycle with `in_valid` and `in_ready` both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-clock enable; one line bit per high cycle |
| cts | input | 1 | Clear-to-send, active high |
| cts_force | input | 1 | Configuration: treat clear-to-send as always active |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte valid |
| in_last | input | 1 | Byte is the last of its frame |
| in_ready | output | 1 | Holding register empty, byte can be accepted |
| txd | output | 1 | Serial data, NRZ |
| rts | output | 1 | Request-to-send, high while a frame is on the line |
| underrun | output | 1 | Last frame was aborted for lack of data |

## Verification
A scoreboard builds the full expected line bit sequence for each frame, including inserted zeros and the check sequence, and compares it bit for bit with the line. It also compares each frame's length in bit times against the `rts` window. Several payload patterns are used:
- Short mixed bytes check bit order and framing.
- Runs of 0xFF and embedded 0x7E bytes separate correct zero insertion from missing or misplaced insertion.
- The string "123456789" pins the check sequence to a known value.

Further runs cover the remaining behaviour:
- A frame held back with clear-to-send low, then released by the force input, exercises start gating.
- A long stall of the bit enable in mid-frame exercises the hold behaviour.
- Back-to-back frames exercise the gap between frames.
- A frame left without its end marker shows the abort run and the underrun flag, and the next frame start shows the flag being cleared.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
    localparam int          BYTE_W       = 8;
    localparam int          FCS_W        = 16;
    localparam logic [7:0]  FLAG_BYTE    = 8'h7E;
    localparam logic [15:0] FCS_POLY_REV = 16'h8408;
    localparam logic [15:0] FCS_PRESET   = 16'hFFFF;
    localparam int          STUFF_RUN    = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_OPEN,
        ST_DATA,
        ST_FCS,
        ST_CLOSE,
        ST_ABORT
    } tx_state_e;
endpackage

// File: rtl/hdlc_fcs16.sv
module hdlc_fcs16
    import hdlc_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             step,
    input  logic             bit_in,
    output logic [FCS_W-1:0] crc_next
);
    logic [FCS_W-1:0] crc_q, crc_d;
    logic             fb;

    always_comb begin
        fb       = crc_q[0] ^ bit_in;
        crc_next = (crc_q >> 1) ^ (fb ? FCS_POLY_REV : '0);
        crc_d    = crc_q;
        if (init)      crc_d = FCS_PRESET;
        else if (step) crc_d = crc_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= FCS_PRESET;
        else        crc_q <= crc_d;
    end

    // R5
    fcs_init_step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(init && step));
endmodule

// File: rtl/hdlc_zero_insert.sv
module hdlc_zero_insert
    import hdlc_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic shift,
    input  logic bit_in,
    output logic full
);
    logic [2:0] ones_q, ones_d;

    always_comb begin
        ones_d = ones_q;
        if (clr)        ones_d = '0;
        else if (shift) ones_d = bit_in ? ones_q + 3'd1 : 3'd0;
        full = (ones_q == 3'(STUFF_RUN));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ones_q <= '0;
        else        ones_q <= ones_d;
    end

    // R6
    no_shift_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !shift);
endmodule

// File: rtl/hdlc_frame_tx.sv
module hdlc_frame_tx
    import hdlc_tx_pkg::*;
#(
    parameter int LEAD_BITS  = 2,
    parameter int ABORT_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              cts,
    input  logic              cts_force,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic              txd,
    output logic              rts,
    output logic              underrun
);
    localparam int MAX_A = (ABORT_BITS > LEAD_BITS) ? ABORT_BITS : LEAD_BITS;
    localparam int MAXC  = (MAX_A > FCS_W) ? MAX_A : FCS_W;
    localparam int CNT_W = $clog2(MAXC + 1);

    typedef struct packed {
        tx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [FCS_W-1:0]  sh;
        logic              last;
        logic              hold_v;
        logic [BYTE_W-1:0] hold_d;
        logic              hold_last;
        logic              txd;
        logic              rts;
        logic              underrun;
    } regs_t;

    regs_t q, n;
    logic  cts_ok, take;
    logic  crc_init, crc_step;
    logic  stf_clr, stf_shift, stf_full;
    logic [FCS_W-1:0] crc_next;

    assign cts_ok = cts | cts_force;

    hdlc_fcs16 u_fcs (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (crc_init),
        .step     (crc_step),
        .bit_in   (q.sh[0]),
        .crc_next (crc_next)
    );

    hdlc_zero_insert u_stuff (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (stf_clr),
        .shift  (stf_shift),
        .bit_in (q.sh[0]),
        .full   (stf_full)
    );

    always_comb begin
        n         = q;
        take      = 1'b0;
        crc_init  = 1'b0;
        crc_step  = 1'b0;
        stf_clr   = 1'b0;
        stf_shift = 1'b0;
        if (bit_en) begin
            unique case (q.state)
                ST_IDLE: begin
                    n.txd = 1'b1;
                    n.rts = 1'b0;
                    if (q.hold_v && !q.rts && cts_ok) begin
                        n.state    = ST_LEAD;
                        n.cnt      = CNT_W'(1);
                        n.rts      = 1'b1;
                        n.underrun = 1'b0;
                    end
                end
                ST_LEAD: begin
                    if (q.cnt == CNT_W'(LEAD_BITS)) begin
                        n.state = ST_OPEN;
                        n.txd   = FLAG_BYTE[0];
                        n.cnt   = CNT_W'(1);
                    end else begin
                        n.txd = 1'b1;
                        n.cnt = q.cnt + 1'b1;
                    end
                end
                ST_OPEN: begin
                    n.txd = FLAG_BYTE[q.cnt[2:0]];
                    if (q.cnt == CNT_W'(7)) begin
                        take     = 1'b1;
                        n.sh     = {{(FCS_W-BYTE_W){1'b0}}, q.hold_d};
                        n.last   = q.hold_last;
                        n.state  = ST_DATA;
                        n.cnt    = '0;
                        crc_init = 1'b1;
                        stf_clr  = 1'b1;
                    end else begin
                        n.cnt = q.cnt + 1'b1;
                    end
                end
                ST_DATA, ST_FCS: begin
                    if (stf_full) begin
                        n.txd   = 1'b0;
                        stf_clr = 1'b1;
                    end else begin
                        n.txd     = q.sh[0];
                        n.sh      = q.sh >> 1;
                        n.cnt     = q.cnt + 1'b1;
                        stf_shift = 1'b1;
                        crc_step  = (q.state == ST_DATA);
                        if (q.state == ST_DATA && q.cnt == CNT_W'(BYTE_W-1)) begin
                            n.cnt = '0;
                            if (q.last) begin
                                n.state = ST_FCS;
                                n.sh    = ~crc_next;
                            end else if (q.hold_v) begin
                                take   = 1'b1;
                                n.sh   = {{(FCS_W-BYTE_W){1'b0}}, q.hold_d};
                                n.last = q.hold_last;
                            end else begin
                                n.state    = ST_ABORT;
                                n.underrun = 1'b1;
                            end
                        end
                        if (q.state == ST_FCS && q.cnt == CNT_W'(FCS_W-1)) begin
                            n.state = ST_CLOSE;
                            n.cnt   = '0;
                        end
                    end
                end
                ST_CLOSE: begin
                    if (stf_full) begin
                        n.txd   = 1'b0;
                        stf_clr = 1'b1;
                    end else begin
                        n.txd = FLAG_BYTE[q.cnt[2:0]];
                        if (q.cnt == CNT_W'(7)) begin
                            n.state = ST_IDLE;
                            n.cnt   = '0;
                        end else begin
                            n.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_ABORT: begin
                    n.txd = 1'b1;
                    if (q.cnt == CNT_W'(ABORT_BITS-1)) begin
                        n.state = ST_IDLE;
                        n.cnt   = '0;
                    end else begin
                        n.cnt = q.cnt + 1'b1;
                    end
                end
                default: n.state = ST_IDLE;
            endcase
        end
        if (take) begin
            n.hold_v = 1'b0;
        end else if (in_valid && !q.hold_v) begin
            n.hold_v    = 1'b1;
            n.hold_d    = in_data;
            n.hold_last = in_last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.txd   <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign in_ready = !q.hold_v;
    assign txd      = q.txd;
    assign rts      = q.rts;
    assign underrun = q.underrun;

    // R1
    idle_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.rts |-> q.txd);
    // R2
    start_needs_cts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rts) |-> $past(cts_ok) && $past(bit_en));
    // R3
    lead_is_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rts) |-> q.txd);
    // R6
    stuff_emits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && stf_full && (q.state == ST_DATA || q.state == ST_FCS || q.state == ST_CLOSE))
        |=> !q.txd);
    // R7
    rts_fall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.rts) |-> (q.state == ST_IDLE));
    // R8
    underrun_on_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.underrun) |-> (q.state == ST_ABORT));
    // R9
    hold_without_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(q.txd) && $stable(q.rts));
endmodule

// File: tb/hdlc_frame_tx_tb.sv
`timescale 1ns/1ps
module hdlc_frame_tx_tb;
    localparam int LEAD  = 2;
    localparam int ABRT  = 8;
    localparam logic [7:0] FLAG = 8'h7E;

    logic clk = 0, rst_n = 0, bit_en = 0, cts = 0, cts_force = 0;
    logic in_valid = 0, in_last = 0;
    logic [7:0] in_data = 0;
    logic in_ready, txd, rts, underrun;

    always #2.5 clk = ~clk;

    hdlc_frame_tx #(.LEAD_BITS(LEAD), .ABORT_BITS(ABRT)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cts(cts), .cts_force(cts_force),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .txd(txd), .rts(rts), .underrun(underrun)
    );

    int checks = 0, errors = 0;
    bit exp_bits[$];
    int exp_len[$];
    bit pause = 0, mon_on = 0, in_frame = 0;
    int div = 0, fcnt = 0, mlen = 0;
    bit prev_txd = 1, prev_rts = 0, ebit = 0;
    int ones = 0, nbits = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_upd(logic [15:0] c, bit b);
        bit fb = c[0] ^ b;
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
        return c;
    endfunction

    // monitor and bit-enable generator, one process so no edge race
    always @(negedge clk) begin
        if (mon_on) begin
            if (bit_en) begin
                if (rts) begin
                    if (!in_frame) begin in_frame = 1; fcnt = 0; end
                    if (exp_bits.size() == 0) chk(0, "R3 unexpected frame bit", txd, -1);
                    else begin
                        ebit = exp_bits.pop_front();
                        chk(txd == ebit, "R3/R4/R5/R6 line bit", txd, ebit);
                    end
                    fcnt++;
                end else begin
                    if (in_frame) begin
                        in_frame = 0;
                        if (exp_len.size() == 0) chk(0, "R7 unexpected frame end", fcnt, -1);
                        else begin
                            mlen = exp_len.pop_front();
                            chk(fcnt == mlen, "R7 frame length in bit times", fcnt, mlen);
                        end
                    end
                    chk(txd == 1, "R1 idle fill", txd, 1);
                end
            end else begin
                chk(txd == prev_txd && rts == prev_rts, "R9 hold without bit enable",
                    {txd, rts}, {prev_txd, prev_rts});
            end
        end
        prev_txd = txd;
        prev_rts = rts;
        div = (div + 1) % 4;
        bit_en = (div == 0) && !pause;
    end

    task automatic put_stuffed(bit x);
        if (ones == 5) begin exp_bits.push_back(0); nbits++; ones = 0; end
        exp_bits.push_back(x); nbits++;
        ones = x ? ones + 1 : 0;
    endtask

    task automatic send_frame(input logic [7:0] b[$], input bit with_last);
        logic [15:0] crc = 16'hFFFF;
        logic [15:0] fcs;
        nbits = 0; ones = 0;
        for (int i = 0; i < LEAD; i++) begin exp_bits.push_back(1); nbits++; end
        for (int i = 0; i < 8; i++) begin exp_bits.push_back(FLAG[i]); nbits++; end
        foreach (b[k]) begin
            for (int i = 0; i < 8; i++) begin
                put_stuffed(b[k][i]);
                crc = crc_upd(crc, b[k][i]);
            end
        end
        if (with_last) begin
            fcs = ~crc;
            for (int i = 0; i < 16; i++) put_stuffed(fcs[i]);
            if (ones == 5) begin exp_bits.push_back(0); nbits++; end
            for (int i = 0; i < 8; i++) begin exp_bits.push_back(FLAG[i]); nbits++; end
        end else begin
            for (int i = 0; i < ABRT; i++) begin exp_bits.push_back(1); nbits++; end
        end
        exp_len.push_back(nbits);
        foreach (b[k]) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1;
            in_data  = b[k];
            in_last  = with_last && (k == b.size() - 1);
            @(negedge clk);
            in_valid = 0;
            in_last  = 0;
        end
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (exp_len.size() != 0 || in_frame) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R7 actual=%0d expected=%0d", exp_len.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] c;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(txd == 1, "R1 reset txd", txd, 1);
        chk(rts == 0, "R1 reset rts", rts, 0);
        chk(underrun == 0, "R1 reset underrun", underrun, 0);
        chk(in_ready == 1, "R10 reset ready", in_ready, 1);
        mon_on = 1;

        // R2: held byte but clear-to-send inactive
        send_frame('{8'hA5}, 1);
        @(negedge clk);
        chk(in_ready == 0, "R10 ready low while holding", in_ready, 0);
        repeat (200) @(negedge clk);
        chk(rts == 0, "R2 no start without clear-to-send", rts, 0);
        cts_force = 1;
        wait_done();
        cts_force = 0;
        cts = 1;

        // R4: plain bytes
        send_frame('{8'h41, 8'h42}, 1);
        wait_done();
        // R6: long ones runs and embedded flag patterns
        send_frame('{8'hFF, 8'hFF, 8'h7E, 8'h3F, 8'hF8}, 1);
        wait_done();
        // R9: stall the bit enable in mid-frame
        fork
            send_frame('{8'h55, 8'hAA, 8'h0F}, 1);
            begin
                repeat (150) @(negedge clk);
                pause = 1;
                repeat (60) @(negedge clk);
                pause = 0;
            end
        join
        wait_done();
        // R5: known check value
        c = 16'hFFFF;
        for (int k = 0; k < 9; k++)
            for (int i = 0; i < 8; i++) c = crc_upd(c, (8'h31 + k) >> i);
        chk(~c == 16'h906E, "R5 model check value", ~c, 16'h906E);
        send_frame('{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39}, 1);
        wait_done();
        // R7: back-to-back frames
        send_frame('{8'h00}, 1);
        send_frame('{8'hFE, 8'h01}, 1);
        wait_done();
        // R8: underrun abort
        send_frame('{8'h0F, 8'h30}, 0);
        wait_done();
        chk(underrun == 1, "R8 underrun set after abort", underrun, 1);
        send_frame('{8'h01}, 1);
        while (!rts) @(negedge clk);
        chk(underrun == 0, "R8 underrun cleared at next start", underrun, 0);
        wait_done();
        chk(exp_bits.size() == 0, "R7 all expected bits sent", exp_bits.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule